// File: doc/BRIEF.md
# Logical and Arithmetic Barrel Shifter

This block shifts a 32-bit operand left or right by zero to thirty-one places in a single pass through its logic. Three kinds of shift are supported: a left shift that feeds zeros in at the low end, a right shift that feeds zeros in at the high end, and a right shift that copies the operand's top bit into every vacated position. Each kind comes in two forms. One takes its distance from a 5-bit constant field carried with the operation. The other takes it from the low five bits of a 32-bit register operand.

A 6-bit function code picks the kind of shift and the source of the distance. The shift logic is built as five conditional stages, shifting by 16, 8, 4, 2 and 1 places, so its depth grows with the logarithm of the width.

The result and a flag marking a recognised code are both registered. They appear one clock after the inputs are presented. An unrecognised code yields a zero result with the flag low.

Top module: `bshift_unit`

## Requirements
- R1: Function codes 0 (left, constant amount), 2 (right logical, constant), 3 (right arithmetic, constant), 4 (left, register amount), 6 (right logical, register) and 7 (right arithmetic, register) are recognised; for these, `res_valid` is 1 in the cycle after the inputs are sampled.
- R2: A left shift by n moves every bit n places toward the MSB and fills the n low bits with zero, e.g. 0xabcd1234 shifted left 8 gives 0xcd123400.
- R3: A logical right shift by n fills the n high bits with zero, e.g. 0xabcd1234 by 4 gives 0x0abcd123, and by 16 gives 0x0000abcd.
- R4: An arithmetic right shift by n fills the n high bits with copies of operand bit 31, e.g. 0xabcd1234 by 4 gives 0xfabcd123.
- R5: Codes 0, 2 and 3 take the distance from `imm_amt`, and `reg_amt` has no effect on the result.
- R6: Codes 4, 6 and 7 take the distance from `reg_amt[4:0]` only; `reg_amt[31:5]` and `imm_amt` have no effect on the result.
- R7: A distance of 0 returns the operand unchanged for all six codes.
- R8: Any other function code gives `res_valid` = 0 and `res_out` = 0 in the following cycle.
- R9: Synchronous active-high `rst` clears `res_out` and `res_valid` to 0 at the next clock edge. The outputs are registered with a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 32 | Operand to shift |
| imm_amt | input | 5 | Constant shift distance field |
| reg_amt | input | 32 | Register operand holding a variable distance |
| func_code | input | 6 | Function code selecting kind and distance source |
| res_out | output | 32 | Registered shift result |
| res_valid | output | 1 | Registered flag: the code was a recognised shift |

## Verification
The hardest case to reach from the ports is a register-sourced shift in which the low five distance bits are zero but the discarded upper bits and the constant field are not. Any leak from an ignored field shows up only in that case, and only as a wrong nonzero shift. A second hard case is a full 31-place arithmetic shift of a negative operand, where every stage must apply the fill. The stimulus sweeps every code against every distance from 0 to 31. While it does so, the ignored fields carry random noise and operands are drawn from both signs, so both situations come up many times. A separate pass walks all 64 function codes so that every unrecognised one is checked.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [5:0] {
    FC_SHL_IMM = 6'd0,
    FC_SHR_IMM = 6'd2,
    FC_SAR_IMM = 6'd3,
    FC_SHL_VAR = 6'd4,
    FC_SHR_VAR = 6'd6,
    FC_SAR_VAR = 6'd7
  } func_e;

  typedef struct packed {
    logic ok;
    logic left;
    logic arith;
    logic use_var;
  } ctrl_t;

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [5:0]    func_code,
  input  logic [AW-1:0] imm_amt,
  input  logic [W-1:0]  reg_amt,
  output ctrl_t         ctrl,
  output logic [AW-1:0] amt
);

  logic unused_hi;
  assign unused_hi = ^reg_amt[W-1:AW];

  always_comb begin
    ctrl = '0;
    case (func_code)
      FC_SHL_IMM: ctrl = '{ok: 1'b1, left: 1'b1, arith: 1'b0, use_var: 1'b0};
      FC_SHR_IMM: ctrl = '{ok: 1'b1, left: 1'b0, arith: 1'b0, use_var: 1'b0};
      FC_SAR_IMM: ctrl = '{ok: 1'b1, left: 1'b0, arith: 1'b1, use_var: 1'b0};
      FC_SHL_VAR: ctrl = '{ok: 1'b1, left: 1'b1, arith: 1'b0, use_var: 1'b1};
      FC_SHR_VAR: ctrl = '{ok: 1'b1, left: 1'b0, arith: 1'b0, use_var: 1'b1};
      FC_SAR_VAR: ctrl = '{ok: 1'b1, left: 1'b0, arith: 1'b1, use_var: 1'b1};
      default:    ctrl = '0;
    endcase
  end

  // Only the low AW bits of the register operand ever reach the distance
  always_comb amt = ctrl.use_var ? reg_amt[AW-1:0] : imm_amt;

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int W = 32,
  parameter int S = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  logic         left,
  input  logic         fill,
  output logic [W-1:0] dout
);

  always_comb begin
    if (!en)
      dout = din;
    else if (left)
      dout = {din[W-S-1:0], {S{1'b0}}};
    else
      dout = {{S{fill}}, din[W-1:S]};
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [0:AW];
  logic         fill;

  assign stg[0] = din;
  // Fill comes from the original operand's top bit, the same for every stage
  assign fill   = arith & din[W-1];

  for (genvar k = 0; k < AW; k++) begin : g_stage
    bshift_stage #(.W(W), .S(1 << k)) u_stage (
      .din  (stg[k]),
      .en   (amt[k]),
      .left (left),
      .fill (fill),
      .dout (stg[k+1])
    );
  end

  assign dout = stg[AW];

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_val,
  input  logic [AW-1:0] imm_amt,
  input  logic [W-1:0]  reg_amt,
  input  logic [5:0]    func_code,
  output logic [W-1:0]  res_out,
  output logic          res_valid
);

  ctrl_t         ctrl;
  logic [AW-1:0] amt;
  logic [W-1:0]  shifted;

  bshift_decode #(.W(W), .AW(AW)) u_decode (
    .func_code (func_code),
    .imm_amt   (imm_amt),
    .reg_amt   (reg_amt),
    .ctrl      (ctrl),
    .amt       (amt)
  );

  bshift_core #(.W(W), .AW(AW)) u_core (
    .din   (src_val),
    .amt   (amt),
    .left  (ctrl.left),
    .arith (ctrl.arith),
    .dout  (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= ctrl.ok;
      res_out   <= ctrl.ok ? shifted : '0;
    end
  end

  // R9: reset clears both outputs
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (res_out == '0 && !res_valid));

  // R8: an unrecognised code leaves a zero result
  a_r8_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> res_out == '0);

  // R1: flag follows recognition of the code one cycle later
  a_r1_valid_code: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> res_valid == $past(func_code inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7}));

  // R7: zero distance passes the operand through
  a_r7_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ok && amt == '0) |=> res_out == $past(src_val));

  // R2: a nonzero left shift leaves bit 0 clear
  a_r2_lsb_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ok && ctrl.left && amt != '0) |=> !res_out[0]);

  // R3: a nonzero logical right shift leaves the top bit clear
  a_r3_msb_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ok && !ctrl.left && !ctrl.arith && amt != '0) |=> !res_out[W-1]);

  // R4: arithmetic right shift keeps the sign bit
  a_r4_sign_keep: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ok && ctrl.arith) |=> res_out[W-1] == $past(src_val[W-1]));

endmodule

// File: tb/bshift_unit_tb_top.sv
`timescale 1ns/1ps
module bshift_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_val   = '0;
  logic [4:0]  imm_amt   = '0;
  logic [31:0] reg_amt   = '0;
  logic [5:0]  func_code = '0;
  logic [31:0] res_out;
  logic        res_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bshift_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .src_val   (src_val),
    .imm_amt   (imm_amt),
    .reg_amt   (reg_amt),
    .func_code (func_code),
    .res_out   (res_out),
    .res_valid (res_valid)
  );

  function automatic bit code_ok(input logic [5:0] fc);
    return (fc == 6'd0 || fc == 6'd2 || fc == 6'd3 ||
            fc == 6'd4 || fc == 6'd6 || fc == 6'd7);
  endfunction

  // Arithmetic reference: multiply or divide by a power of two
  function automatic logic [31:0] model(input logic [5:0] fc, input logic [31:0] v,
                                        input logic [4:0] ia, input logic [31:0] ra);
    int     n;
    longint p;
    longint s;
    longint r;
    if (!code_ok(fc)) return 32'h0;
    n = (fc >= 6'd4) ? int'(ra[4:0]) : int'(ia);
    p = 1;
    for (int i = 0; i < n; i++) p = p * 2;
    if (fc == 6'd0 || fc == 6'd4) begin
      r = (longint'(v) * p) % 64'sh1_0000_0000;
    end else if (fc == 6'd2 || fc == 6'd6) begin
      r = longint'(v) / p;
    end else begin
      s = longint'($signed(v));
      if (s < 0) r = (s - (p - 1)) / p;
      else       r = s / p;
    end
    return r[31:0];
  endfunction

  task automatic apply_check(input logic [5:0] fc, input logic [31:0] v,
                             input logic [4:0] ia, input logic [31:0] ra,
                             input string tag);
    logic [31:0] exp_r;
    bit          exp_v;
    @(negedge clk);
    func_code = fc; src_val = v; imm_amt = ia; reg_amt = ra;
    exp_r = model(fc, v, ia, ra);
    exp_v = code_ok(fc);
    @(negedge clk);
    n_run++;
    if (res_out !== exp_r || res_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s fc=%0d v=%h ia=%0d ra=%h: got %h/%b expected %h/%b",
               tag, fc, v, ia, ra, res_out, res_valid, exp_r, exp_v);
    end
  endtask

  function automatic string tag_for(input logic [5:0] fc, input int n);
    string src;
    src = (fc >= 6'd4) ? "R6" : "R5";
    if (n == 0)                       return {"R7,", src};
    if (fc == 6'd0 || fc == 6'd4)     return {"R2,", src};
    if (fc == 6'd2 || fc == 6'd6)     return {"R3,", src};
    return {"R4,", src};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0]  codes [6];
    logic [31:0] v;
    logic [31:0] ra;
    logic [4:0]  ia;
    codes = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7};

    // R9: reset state, with a valid operation held on the inputs
    func_code = 6'd3; src_val = 32'h8000_0001; imm_amt = 5'd1;
    repeat (3) @(negedge clk);
    n_run++;
    if (res_out !== 32'h0 || res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: got %h/%b expected 00000000/0", res_out, res_valid);
    end
    rst = 1'b0;

    // Known vectors (R1, R2, R3, R4)
    apply_check(6'd0, 32'habcd1234, 5'd8,  32'h0,        "R1,R2 left 8");
    apply_check(6'd2, 32'habcd1234, 5'd4,  32'h0,        "R1,R3 right 4");
    apply_check(6'd3, 32'habcd1234, 5'd4,  32'h0,        "R1,R4 arith 4");
    apply_check(6'd6, 32'habcd1234, 5'd0,  32'd16,       "R1,R3 var right 16");
    apply_check(6'd7, 32'h8000_0000, 5'd0, 32'hffff_ffff, "R4,R6 arith 31");
    apply_check(6'd4, 32'h1234_5678, 5'd9, 32'hffff_ffe0, "R6,R7 var zero with noise");

    // Sweep: every code, every distance, mixed operands, noise on ignored fields
    foreach (codes[c]) begin
      for (int n = 0; n < 32; n++) begin
        for (int k = 0; k < 6; k++) begin
          case (k)
            0: v = 32'hffff_ffff;
            1: v = 32'h8000_0000;
            2: v = 32'h0000_0001;
            default: v = $urandom;
          endcase
          if (codes[c] >= 6'd4) begin
            ra = ($urandom & 32'hffff_ffe0) | 32'(n);
            ia = 5'($urandom);
          end else begin
            ra = $urandom;
            ia = 5'(n);
          end
          apply_check(codes[c], v, ia, ra, tag_for(codes[c], n));
        end
      end
    end

    // R8 and R1: all 64 function codes
    for (int f = 0; f < 64; f++) begin
      apply_check(6'(f), $urandom, 5'($urandom), $urandom,
                  code_ok(6'(f)) ? "R1 code walk" : "R8 code walk");
    end

    // R9: synchronous reset mid-stream clears outputs at the next edge
    @(negedge clk);
    func_code = 6'd0; src_val = 32'h0000_00ff; imm_amt = 5'd4; rst = 1'b1;
    @(negedge clk);
    n_run++;
    if (res_out !== 32'h0 || res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 mid reset: got %h/%b expected 00000000/0", res_out, res_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    n_run++;
    if (res_out !== 32'h0000_0ff0 || res_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 after reset: got %h/%b expected 00000ff0/1", res_out, res_valid);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule